// File: doc/BRIEF.md
# ADC Calibration and Setup Sequencer

This block brings a serial 12-bit-plus-sign converter into service after reset. A one-cycle `start` pulse runs a fixed sequence over an SPI master port. The block first sends the self-calibration command, then reads status once and throws that read away. It then waits for an end-of-conversion edge and reads status a second time. If the calibration-busy bit is clear, it sends the command that sets the sample-and-hold acquisition time. The acquisition time comes from a configuration input, and 10 periods is used when no value has been given.

The command encoder can be built for either device variant. The full-mux variant sends command bytes as they are. The reduced-mux variant sends them with their bits moved. On the SPI port, the sequencer assembles the status word from the two bytes it receives. The end-of-conversion wait has a limit in system clock cycles. The result of each run is reported on three flags, and the flags hold their value until the next run starts.

Top module: `adc_bringup_seq`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `spi_sclk` is 0, and `done`, `error` and `timeout` are 0. No frame is sent until `start` is seen in the idle state. No frame is sent after a run ends.
- R2: Each frame is SPI mode 0, sent MSB first, with `spi_cs_n` low for the whole frame. `spi_sclk` is low while the chip select is high. `spi_mosi` changes only while `spi_sclk` is low, and `spi_miso` is sampled on the rising clock edge. A command frame is 8 clocks long. A status frame is 16 clocks long, and its second byte is all zeros.
- R3: The frames go out in this order: calibrate 0x08 (8 clocks), status 0x0C (16), the wait for end-of-conversion, status 0x0C (16), then the acquisition command (8).
- R4: The data returned by the first status read has no effect. A busy bit in that read does not stop the sequence.
- R5: The status word is 9 bits: the first received byte shifted left by one, ORed with the MSB of the second byte. Status bit 6 is bit 5 of the first byte. When that bit is set, the run ends with `error`=1 and `done`=1, and no acquisition frame is sent. No other status bit affects the outcome.
- R6: A requested acquisition time of 6, 10, 18 or 34 periods sends 0x0E, 0x4E, 0x8E or 0xCE. Any other value ends the run with `error`=1 after the second status read, and no acquisition frame is sent.
- R7: When `acq_set` is 0 at start, 10 periods (0x4E) is used, whatever `acq_clocks` holds.
- R8: Any rising edge of `eoc` after `start` releases the wait, including an edge that comes during the earlier frames. Edges seen before `start` are forgotten.
- R9: If no edge has been seen after `TIMEOUT_CYC` cycles in the wait, the run ends with `timeout`=1, `error`=1 and `done`=1, and no further frames are sent.
- R10: With `NARROW_MUX`=1, every command byte b is sent as {b[7:6], b[3:0], 2'b00}.
- R11: Every run ends with `done`=1. `error` and `timeout` are 1 only for the failures above. All three flags hold until the next accepted `start`, and a `start` pulse during a run is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a bring-up run from idle |
| acq_set | input | 1 | 1 when `acq_clocks` holds a requested acquisition time |
| acq_clocks | input | ACQ_W | Requested acquisition time in conversion-clock periods |
| eoc | input | 1 | End-of-conversion signal from the converter |
| spi_sclk | output | 1 | SPI serial clock |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | Serial data to the converter |
| spi_miso | input | 1 | Serial data from the converter |
| done | output | 1 | Run finished |
| error | output | 1 | Run failed |
| timeout | output | 1 | Run failed because the end-of-conversion wait expired |

## Verification
The bench sweeps every requested acquisition time from 0 to 40. A wrong code table shows up as a wrong fourth frame, or as a fourth frame where none should be sent. The bench places the busy bit alone and also surrounds it with every other status bit set. A status assembly off by one bit would then flag busy on the wrong bit or miss it entirely. It also sets the busy bit only in the discarded read, which catches a design that tests the first status read. It fires `eoc` during the first status frame and also only before `start`, against both instances built for the two device variants. This exposes an edge detector that is armed too late or never cleared, which would either time out or skip the wait.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CAL,
      ST_STAT1,
      ST_WAIT,
      ST_STAT2,
      ST_ACQ
   } seq_st_e;

   typedef enum logic [1:0] {
      CMD_CAL,
      CMD_STAT,
      CMD_ACQ
   } cmd_e;

   localparam logic [7:0] CODE_CAL    = 8'h08;
   localparam logic [7:0] CODE_STAT   = 8'h0C;
   localparam logic [7:0] CODE_ACQ6   = 8'h0E;
   localparam logic [7:0] CODE_ACQ10  = 8'h4E;
   localparam logic [7:0] CODE_ACQ18  = 8'h8E;
   localparam logic [7:0] CODE_ACQ34  = 8'hCE;
   localparam int         DEFAULT_ACQ = 10;
   localparam int         STAT_W      = 9;
   localparam int         BUSY_BIT    = 6;

endpackage

// File: rtl/adc_seq_cmd.sv
module adc_seq_cmd
   import adc_seq_pkg::*;
#(
   parameter int NARROW_MUX = 0,
   parameter int ACQ_W      = 6
) (
   input  cmd_e             sel,
   input  logic             acq_set,
   input  logic [ACQ_W-1:0] acq_clocks,
   output logic [7:0]       cmd_byte,
   output logic             acq_ok
);

   logic [7:0] acq_code;
   logic [7:0] raw_byte;
   int         acq_eff;

   always_comb begin
      acq_eff  = acq_set ? int'(acq_clocks) : DEFAULT_ACQ;
      acq_ok   = 1'b1;
      acq_code = CODE_ACQ10;
      case (acq_eff)
         6:       acq_code = CODE_ACQ6;
         10:      acq_code = CODE_ACQ10;
         18:      acq_code = CODE_ACQ18;
         34:      acq_code = CODE_ACQ34;
         default: acq_ok   = 1'b0;
      endcase
   end

   always_comb begin
      case (sel)
         CMD_CAL: raw_byte = CODE_CAL;
         CMD_ACQ: raw_byte = acq_code;
         default: raw_byte = CODE_STAT;
      endcase
   end

   generate
      if (NARROW_MUX != 0) begin : g_narrow
         assign cmd_byte = {raw_byte[7:6], raw_byte[3:0], 2'b00};
      end else begin : g_wide
         assign cmd_byte = raw_byte;
      end
   endgenerate

endmodule

// File: rtl/adc_seq_spi.sv
module adc_seq_spi #(
   parameter int SCLK_HALF = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       go,
   input  logic       len16,
   input  logic [7:0] cmd,
   input  logic       miso,
   output logic       sclk,
   output logic       cs_n,
   output logic       mosi,
   output logic       fin,
   output logic [8:0] rx_lead
);

   localparam int FRAME_MAX = 16;
   localparam int BCW       = $clog2(FRAME_MAX);
   localparam int HCW       = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;
   localparam logic [HCW-1:0] HALF_LAST = HCW'(SCLK_HALF - 1);

   logic                 active;
   logic [HCW-1:0]       half_cnt;
   logic [BCW-1:0]       bit_idx;
   logic [BCW-1:0]       last_idx;
   logic [FRAME_MAX-1:0] tx_sr;
   logic [FRAME_MAX-1:0] rx_sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active   <= 1'b0;
         half_cnt <= '0;
         bit_idx  <= '0;
         last_idx <= '0;
         tx_sr    <= '0;
         rx_sr    <= '0;
         sclk     <= 1'b0;
         fin      <= 1'b0;
      end else begin
         fin <= 1'b0;
         if (!active) begin
            if (go) begin
               active   <= 1'b1;
               tx_sr    <= {cmd, 8'h00};
               last_idx <= len16 ? BCW'(FRAME_MAX - 1) : BCW'(7);
               bit_idx  <= '0;
               half_cnt <= '0;
               rx_sr    <= '0;
               sclk     <= 1'b0;
            end
         end else if (half_cnt == HALF_LAST) begin
            half_cnt <= '0;
            if (!sclk) begin
               sclk  <= 1'b1;
               rx_sr <= {rx_sr[FRAME_MAX-2:0], miso};
            end else begin
               sclk <= 1'b0;
               if (bit_idx == last_idx) begin
                  active <= 1'b0;
                  fin    <= 1'b1;
                  tx_sr  <= '0;
               end else begin
                  bit_idx <= bit_idx + 1'b1;
                  tx_sr   <= {tx_sr[FRAME_MAX-2:0], 1'b0};
               end
            end
         end else begin
            half_cnt <= half_cnt + 1'b1;
         end
      end
   end

   assign cs_n    = ~active;
   assign mosi    = tx_sr[FRAME_MAX-1];
   assign rx_lead = rx_sr[FRAME_MAX-1:FRAME_MAX-9];

endmodule

// File: rtl/adc_seq_eoc.sv
module adc_seq_eoc #(
   parameter int TIMEOUT_CYC = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic wait_en,
   input  logic eoc,
   output logic seen,
   output logic expired
);

   localparam int CW = $clog2(TIMEOUT_CYC + 1);
   localparam logic [CW-1:0] CNT_LAST = CW'(TIMEOUT_CYC - 1);

   logic          eoc_q;
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         eoc_q <= 1'b0;
         seen  <= 1'b0;
         cnt   <= '0;
      end else begin
         eoc_q <= eoc;
         if (arm)
            seen <= 1'b0;
         else if (eoc && !eoc_q)
            seen <= 1'b1;
         if (!wait_en)
            cnt <= '0;
         else if (cnt != CNT_LAST)
            cnt <= cnt + 1'b1;
      end
   end

   assign expired = wait_en && (cnt == CNT_LAST);

endmodule

// File: rtl/adc_bringup_seq.sv
module adc_bringup_seq
   import adc_seq_pkg::*;
#(
   parameter int NARROW_MUX  = 0,
   parameter int ACQ_W       = 6,
   parameter int SCLK_HALF   = 2,
   parameter int TIMEOUT_CYC = 10_000_000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             acq_set,
   input  logic [ACQ_W-1:0] acq_clocks,
   input  logic             eoc,
   output logic             spi_sclk,
   output logic             spi_cs_n,
   output logic             spi_mosi,
   input  logic             spi_miso,
   output logic             done,
   output logic             error,
   output logic             timeout
);

   localparam logic [STAT_W-1:0] BUSY_MASK = STAT_W'(1) << BUSY_BIT;

   generate
      if (SCLK_HALF < 1) begin : g_bad_half
         $error("SCLK_HALF must be at least 1");
      end
      if (TIMEOUT_CYC < 2) begin : g_bad_timeout
         $error("TIMEOUT_CYC must be at least 2");
      end
      if (ACQ_W < 6) begin : g_bad_acq
         $error("ACQ_W must hold the value 34");
      end
   endgenerate

   seq_st_e          st;
   cmd_e             cmd_sel;
   logic             go;
   logic             len16;
   logic             acq_set_q;
   logic [ACQ_W-1:0] acq_clk_q;
   logic [7:0]       cmd_byte;
   logic             acq_ok;
   logic             frame_fin;
   logic [8:0]       rx_lead;
   logic [STAT_W-1:0] stat_w;
   logic             cal_busy;
   logic             eoc_seen;
   logic             eoc_expired;

   always_comb begin
      case (st)
         ST_CAL:  cmd_sel = CMD_CAL;
         ST_ACQ:  cmd_sel = CMD_ACQ;
         default: cmd_sel = CMD_STAT;
      endcase
   end

   // status word: first byte moved up one place, MSB of the second byte below it
   assign stat_w   = {rx_lead[8:1], rx_lead[0]};
   assign cal_busy = |(stat_w & BUSY_MASK);

   adc_seq_cmd #(.NARROW_MUX(NARROW_MUX), .ACQ_W(ACQ_W)) u_cmd (
      .sel        (cmd_sel),
      .acq_set    (acq_set_q),
      .acq_clocks (acq_clk_q),
      .cmd_byte   (cmd_byte),
      .acq_ok     (acq_ok)
   );

   adc_seq_spi #(.SCLK_HALF(SCLK_HALF)) u_spi (
      .clk     (clk),
      .rst_n   (rst_n),
      .go      (go),
      .len16   (len16),
      .cmd     (cmd_byte),
      .miso    (spi_miso),
      .sclk    (spi_sclk),
      .cs_n    (spi_cs_n),
      .mosi    (spi_mosi),
      .fin     (frame_fin),
      .rx_lead (rx_lead)
   );

   adc_seq_eoc #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_eoc (
      .clk     (clk),
      .rst_n   (rst_n),
      .arm     ((st == ST_IDLE) && start),
      .wait_en (st == ST_WAIT),
      .eoc     (eoc),
      .seen    (eoc_seen),
      .expired (eoc_expired)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         go        <= 1'b0;
         len16     <= 1'b0;
         done      <= 1'b0;
         error     <= 1'b0;
         timeout   <= 1'b0;
         acq_set_q <= 1'b0;
         acq_clk_q <= '0;
      end else begin
         go <= 1'b0;
         case (st)
            ST_IDLE: if (start) begin
               done      <= 1'b0;
               error     <= 1'b0;
               timeout   <= 1'b0;
               acq_set_q <= acq_set;
               acq_clk_q <= acq_clocks;
               st        <= ST_CAL;
               go        <= 1'b1;
               len16     <= 1'b0;
            end
            ST_CAL: if (frame_fin) begin
               st    <= ST_STAT1;
               go    <= 1'b1;
               len16 <= 1'b1;
            end
            ST_STAT1: if (frame_fin) st <= ST_WAIT;
            ST_WAIT: begin
               if (eoc_seen) begin
                  st    <= ST_STAT2;
                  go    <= 1'b1;
                  len16 <= 1'b1;
               end else if (eoc_expired) begin
                  timeout <= 1'b1;
                  error   <= 1'b1;
                  done    <= 1'b1;
                  st      <= ST_IDLE;
               end
            end
            ST_STAT2: if (frame_fin) begin
               if (cal_busy || !acq_ok) begin
                  error <= 1'b1;
                  done  <= 1'b1;
                  st    <= ST_IDLE;
               end else begin
                  st    <= ST_ACQ;
                  go    <= 1'b1;
                  len16 <= 1'b0;
               end
            end
            ST_ACQ: if (frame_fin) begin
               done <= 1'b1;
               st   <= ST_IDLE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/adc_bringup_seq_chk.sv
module adc_bringup_seq_chk #(
   parameter int ACQ_W = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             acq_set,
   input logic [ACQ_W-1:0] acq_clocks,
   input logic             eoc,
   input logic             spi_sclk,
   input logic             spi_cs_n,
   input logic             spi_mosi,
   input logic             spi_miso,
   input logic             done,
   input logic             error,
   input logic             timeout
);

   // R2
   sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      spi_cs_n |-> !spi_sclk);

   // R2
   mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!spi_cs_n && $rose(spi_sclk)) |-> $stable(spi_mosi));

   // R1
   quiet_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> spi_cs_n);

   // R11
   flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> done);

   // R9
   timeout_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      timeout |-> (error && done));

   // R5
   err_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      error |-> done);

endmodule

bind adc_bringup_seq adc_bringup_seq_chk #(.ACQ_W(ACQ_W)) u_chk (.*);

// File: tb/adc_bringup_seq_test.sv
`timescale 1ns/1ps

module adc_seq_slave_model (
   input  logic        sclk,
   input  logic        cs_n,
   input  logic        mosi,
   output logic        miso,
   input  int          base,
   input  logic [15:0] resp_a,
   input  logic [15:0] resp_b,
   output int          fc
);
   logic [15:0] word;
   logic [15:0] cap;
   int          nbits;
   int          idx;
   logic [15:0] log_dat [16];
   int          log_len [16];

   initial begin
      fc   = 0;
      miso = 1'b0;
   end

   always @(negedge cs_n) begin
      if (fc - base == 1)      word = resp_a;
      else if (fc - base == 2) word = resp_b;
      else                     word = 16'h5A5A;
      cap   = '0;
      nbits = 0;
      idx   = 0;
      miso  = word[15];
   end

   always @(posedge sclk) if (!cs_n) begin
      cap   = {cap[14:0], mosi};
      nbits = nbits + 1;
   end

   always @(negedge sclk) if (!cs_n) begin
      idx  = idx + 1;
      miso = (idx < 16) ? word[15-idx] : 1'b0;
   end

   always @(posedge cs_n) begin
      log_dat[fc % 16] = cap;
      log_len[fc % 16] = nbits;
      fc = fc + 1;
   end
endmodule

module adc_bringup_seq_test;
   localparam int TO_CYC = 300;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic acq_set = 1'b0;
   logic [5:0] acq_clocks = '0;
   logic eoc = 1'b0;
   logic sclk_w, cs_w, mosi_w, miso_w, done_w, err_w, to_w;
   logic sclk_n, cs_n_n, mosi_n, miso_n, done_n, err_n, to_n;
   int   base_w = 0, base_n = 0;
   logic [15:0] resp_a = '0, resp_b = '0;
   int   fc_w, fc_n;
   int   checks = 0, errors = 0;
   bit   finished = 0;

   always #2.5 clk = ~clk;

   adc_bringup_seq #(.NARROW_MUX(0), .SCLK_HALF(2), .TIMEOUT_CYC(TO_CYC)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .acq_set(acq_set),
      .acq_clocks(acq_clocks), .eoc(eoc), .spi_sclk(sclk_w), .spi_cs_n(cs_w),
      .spi_mosi(mosi_w), .spi_miso(miso_w), .done(done_w), .error(err_w),
      .timeout(to_w));

   adc_bringup_seq #(.NARROW_MUX(1), .SCLK_HALF(2), .TIMEOUT_CYC(TO_CYC)) uut_narrow (
      .clk(clk), .rst_n(rst_n), .start(start), .acq_set(acq_set),
      .acq_clocks(acq_clocks), .eoc(eoc), .spi_sclk(sclk_n), .spi_cs_n(cs_n_n),
      .spi_mosi(mosi_n), .spi_miso(miso_n), .done(done_n), .error(err_n),
      .timeout(to_n));

   adc_seq_slave_model sl_w (.sclk(sclk_w), .cs_n(cs_w), .mosi(mosi_w), .miso(miso_w),
      .base(base_w), .resp_a(resp_a), .resp_b(resp_b), .fc(fc_w));
   adc_seq_slave_model sl_n (.sclk(sclk_n), .cs_n(cs_n_n), .mosi(mosi_n), .miso(miso_n),
      .base(base_n), .resp_a(resp_a), .resp_b(resp_b), .fc(fc_n));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] remap(input logic [7:0] b);
      return {b[7:6], b[3:0], 2'b00};
   endfunction

   task automatic pulse_eoc();
      @(negedge clk) eoc = 1'b1;
      @(negedge clk) eoc = 1'b1;
      @(negedge clk) eoc = 1'b0;
   endtask

   // mode 0: edge during wait, 1: edge during first status frame,
   // 2: no edge, 3: edge only before start
   task automatic run_case(input string tag, input logic set, input int clk_v,
                           input logic [15:0] ra, input logic [15:0] rb, input int mode);
      int eff, nexp;
      logic ok;
      logic [7:0] acq_c;
      logic [7:0] codes [4];
      int lens [4];
      bit to_exp, err_exp;
      eff = set ? clk_v : 10;
      ok = 1'b1;
      acq_c = 8'h00;
      case (eff)
         6:  acq_c = 8'h0E;
         10: acq_c = 8'h4E;
         18: acq_c = 8'h8E;
         34: acq_c = 8'hCE;
         default: ok = 1'b0;
      endcase
      codes[0] = 8'h08; codes[1] = 8'h0C; codes[2] = 8'h0C; codes[3] = acq_c;
      lens[0] = 8; lens[1] = 16; lens[2] = 16; lens[3] = 8;
      if (mode >= 2) begin
         nexp = 2; to_exp = 1; err_exp = 1;
      end else if (rb[13] || !ok) begin
         nexp = 3; to_exp = 0; err_exp = 1;
      end else begin
         nexp = 4; to_exp = 0; err_exp = 0;
      end

      @(negedge clk);
      base_w = fc_w; base_n = fc_n;
      resp_a = ra; resp_b = rb;
      acq_set = set; acq_clocks = 6'(clk_v);
      if (mode == 3) begin
         pulse_eoc();
         repeat (3) @(negedge clk);
      end
      start = 1'b1;
      @(negedge clk) start = 1'b0;
      if (mode == 0) begin
         while (fc_w != base_w + 2) @(negedge clk);
         repeat (20) @(negedge clk);
         start = 1'b1;
         @(negedge clk) start = 1'b0;
         repeat (5) @(negedge clk);
         pulse_eoc();
      end else if (mode == 1) begin
         while (!(fc_w == base_w + 1 && !cs_w)) @(negedge clk);
         repeat (4) @(negedge clk);
         pulse_eoc();
      end
      for (int i = 0; i < 4000 && !(done_w && done_n); i++) @(negedge clk);
      repeat (2) @(negedge clk);

      chk({"R11 done wide ", tag}, done_w, 1);
      chk({"R11 done narrow ", tag}, done_n, 1);
      chk({"R5 R6 error wide ", tag}, err_w, err_exp);
      chk({"R5 R6 error narrow ", tag}, err_n, err_exp);
      chk({"R9 timeout wide ", tag}, to_w, to_exp);
      chk({"R9 timeout narrow ", tag}, to_n, to_exp);
      chk({"R3 frame count wide ", tag}, fc_w - base_w, nexp);
      chk({"R3 frame count narrow ", tag}, fc_n - base_n, nexp);
      for (int k = 0; k < nexp; k++) begin
         logic [15:0] ew, en;
         ew = (lens[k] == 16) ? {codes[k], 8'h00} : {8'h00, codes[k]};
         en = (lens[k] == 16) ? {remap(codes[k]), 8'h00} : {8'h00, remap(codes[k])};
         chk({"R2 frame length wide ", tag}, sl_w.log_len[(base_w + k) % 16], lens[k]);
         chk({"R3 R6 frame data wide ", tag}, sl_w.log_dat[(base_w + k) % 16], ew);
         chk({"R2 frame length narrow ", tag}, sl_n.log_len[(base_n + k) % 16], lens[k]);
         chk({"R10 frame data narrow ", tag}, sl_n.log_dat[(base_n + k) % 16], en);
      end
   endtask

   initial begin
      repeat (4) @(negedge clk);
      // R1 reset state
      chk("R1 cs_n after reset", cs_w, 1);
      chk("R1 sclk after reset", sclk_w, 0);
      chk("R1 done after reset", done_w, 0);
      chk("R1 error after reset", err_w, 0);
      chk("R1 timeout after reset", to_w, 0);
      rst_n = 1'b1;
      repeat (10) @(negedge clk);
      chk("R1 no frame before start", fc_w, 0);

      // R6 sweep of requested acquisition times
      for (int v = 0; v <= 40; v++) run_case("R6 sweep", 1'b1, v, 16'h0000, 16'h0000, 0);
      // R7 unconfigured uses 10
      run_case("R7 unset a", 1'b0, 6, 16'h0000, 16'h0000, 0);
      run_case("R7 unset b", 1'b0, 34, 16'h0000, 16'h0000, 0);
      // R4 busy in discarded read
      run_case("R4 first busy", 1'b1, 18, 16'h2000, 16'h0000, 0);
      // R5 status bit position
      run_case("R5 busy", 1'b1, 18, 16'h0000, 16'h2000, 0);
      run_case("R5 others set", 1'b1, 18, 16'h0000, 16'hDF80, 0);
      run_case("R5 stat bit7", 1'b1, 6, 16'h0000, 16'h4000, 0);
      run_case("R5 stat bit0", 1'b1, 6, 16'h0000, 16'h0080, 0);
      run_case("R5 busy bad cfg", 1'b1, 7, 16'h0000, 16'h2000, 0);
      // R8 early edge and stale edge
      run_case("R8 early edge", 1'b1, 34, 16'h0000, 16'h0000, 1);
      run_case("R8 stale edge", 1'b1, 34, 16'h0000, 16'h0000, 3);
      // R9 no edge
      run_case("R9 no edge", 1'b1, 10, 16'h0000, 16'h0000, 2);
      run_case("R9 then ok", 1'b1, 10, 16'h0000, 16'h0000, 0);

      // R11 flags held, R1 nothing sent after the run
      begin
         int f0;
         f0 = fc_w;
         repeat (50) @(negedge clk);
         chk("R11 done held", done_w, 1);
         chk("R11 error held", err_w, 0);
         chk("R1 idle after run", fc_w, f0);
      end

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule